// File: doc/BRIEF.md
# Strided DMA Address Sequencer

This block is a small DMA engine that walks two address streams at once. Software programs a source address, a destination address, a transfer count, a pair of signed strides and a configuration word through a simple register write port. In master mode the block then emits one read-request packet per transfer on a valid/ready output channel. Each packet carries the current source address as the address being read and the current destination address as the return address. The transfer size comes from the configuration word.

The output follows the usual valid/ready rules. `out_valid` is high while the engine has work, and the packet stays frozen until `out_ready` is seen high. A transfer completes only in a cycle where `out_valid` and `out_ready` are both high. On that clock edge, each address moves by its own stride and the count drops by one. When the count reaches zero, valid falls and `done` pulses once. Each stride is a signed 16-bit byte count and can be scaled by 65536 through its own configuration bit.

In slave mode the engine keeps its registers but issues nothing. Clearing the enable bit stops issue once the current cycle's handshake, if there is one, has finished.

Top module: `dma_stride_seq`

## Requirements
- R1: After reset, `out_valid`, `busy` and `done` are 0, and every register is zero, so `out_packet` is all zeros.
- R2: Register writes take effect on the clock edge where `reg_wr_en` is 1. Select 0 is config, 1 is count, 2 is strides, 3 is source address and 4 is destination address. Writes with select 5, 6 or 7 change nothing.
- R3: `out_valid` is 1 exactly when config bit 0 (enable) is 1, config bit 1 (master) is 1 and the count is nonzero.
- R4: The packet layout is as follows. Bit 0 equals `out_valid`. Bit 1 (write) is 0. Bits 3:2 equal config bits 6:5 (00 byte, 01 half-word, 10 word, 11 double word). Bits 7:4 are 0. Bits 39:8 hold the current source address. Bits 71:40 are 0. Bits 103:72 hold the current destination address.
- R5: On a handshake (valid and ready both 1), the following happens at that clock edge. The source address gains the source stride from stride bits 15:0. The destination address gains the destination stride from stride bits 31:16. The count decreases by one. Both strides are signed.
- R6: Config bit 11 multiplies the source stride by 65536, and config bit 12 does the same for the destination stride.
- R7: While `out_valid` is 1 and `out_ready` is 0 and no register is written, `out_valid` stays 1 and `out_packet` stays unchanged.
- R8: `busy` equals enable AND (count nonzero). `done` is 1 for exactly the one cycle after the handshake that takes the count from 1 to 0.
- R9: Writing the count restarts sequencing from the current addresses. If a count write and a handshake share a cycle, the written count wins, no `done` pulse is produced, and the addresses still step.
- R10: If an address write and a handshake share a cycle, the written value wins for that address. The other address still steps.
- R11: If enable is cleared in a cycle that has a handshake, that handshake still completes. From the next cycle no packet is issued, and the registers hold until enable returns.
- R12: In slave mode (config bit 1 = 0), no packet is issued and the programmed addresses and count are kept.
- R13: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select |
| reg_wr_data | input | 32 | Register write data |
| out_valid | output | 1 | Packet valid |
| out_ready | input | 1 | Downstream ready (low = stall) |
| out_packet | output | 104 | Read-request packet |
| busy | output | 1 | Enabled with transfers remaining |
| done | output | 1 | One-cycle completion pulse |

## Verification
The critical overlap is a software register write landing on the same clock edge as an accepted transfer. That edge also wants to step the addresses and decrement the count. The bench holds `out_ready` high while writing the count, then a source address, and finally the enable bit, each mid-stream. The bench model applies the stated priority (the write wins for the written register, the others still step) every cycle. The bench then judges the overlap from the addresses in the following packet, from the number of handshakes left before `done`, and from the absence of a spurious `done` pulse.

// File: rtl/dma_stride_pkg.sv
package dma_stride_pkg;

  localparam int AW    = 32;
  localparam int PKT_W = 104;

  typedef enum logic [2:0] {
    SEL_CFG    = 3'd0,
    SEL_COUNT  = 3'd1,
    SEL_STRIDE = 3'd2,
    SEL_SRC    = 3'd3,
    SEL_DST    = 3'd4
  } reg_sel_e;

  localparam int CFG_EN_BIT     = 0;
  localparam int CFG_MASTER_BIT = 1;
  localparam int CFG_SIZE_LO    = 5;
  localparam int CFG_SSHIFT_BIT = 11;
  localparam int CFG_DSHIFT_BIT = 12;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } xfer_size_e;

  typedef struct packed {
    logic       dshift;
    logic       sshift;
    xfer_size_e size;
    logic       master;
    logic       enable;
  } cfg_t;

  typedef struct packed {
    logic [AW-1:0] ret_addr;
    logic [AW-1:0] payload;
    logic [AW-1:0] tgt_addr;
    logic [3:0]    ctrl;
    xfer_size_e    size;
    logic          write;
    logic          access;
  } pkt_t;

  function automatic cfg_t decode_cfg(input logic [31:0] w);
    cfg_t c;
    c.enable = w[CFG_EN_BIT];
    c.master = w[CFG_MASTER_BIT];
    c.size   = xfer_size_e'(w[CFG_SIZE_LO +: 2]);
    c.sshift = w[CFG_SSHIFT_BIT];
    c.dshift = w[CFG_DSHIFT_BIT];
    return c;
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_stride_pkg::*;
#(
  parameter int STRIDE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [2:0]            wr_sel_i,
  input  logic [31:0]           wr_data_i,
  output cfg_t                  cfg_o,
  output logic [1:0][AW-1:0]    inc_o
);

  localparam int SW2 = 2 * STRIDE_W;

  cfg_t           cfg_q;
  logic [SW2-1:0] stride_q;
  logic [1:0]     shift_sel;
  logic           unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      stride_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_CFG)    cfg_q    <= decode_cfg(wr_data_i);
      if (wr_sel_i == SEL_STRIDE) stride_q <= wr_data_i[SW2-1:0];
    end
  end

  assign unused_wdata = ^{wr_data_i[31:13], wr_data_i[10:7], wr_data_i[4:2]};
  assign shift_sel    = {cfg_q.dshift, cfg_q.sshift};
  assign cfg_o        = cfg_q;

  // index 0 = source stride (low half), index 1 = destination stride (high half)
  for (genvar g = 0; g < 2; g++) begin : g_inc
    logic [STRIDE_W-1:0] raw;
    logic [AW-1:0]       ext;
    assign raw      = stride_q[g*STRIDE_W +: STRIDE_W];
    assign ext      = {{(AW-STRIDE_W){raw[STRIDE_W-1]}}, raw};
    assign inc_o[g] = shift_sel[g] ? (ext << STRIDE_W) : ext;
  end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] inc_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load_i) q <= load_val_i;
    else if (step_i) q <= q + inc_i;
  end

  assign q_o = q;

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(load_val_i)));

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic             nonzero_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (load_i)      cnt_q <= load_val_i;
      else if (step_i) cnt_q <= cnt_q - 1'b1;
      done_q <= step_i && !load_i && (cnt_q == CNT_W'(1));
    end
  end

  assign nonzero_o = |cnt_q;
  assign done_o    = done_q;

  // R5
  step_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cnt_q != '0));

  // R5
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == '0));

endmodule

// File: rtl/dma_pkt_form.sv
module dma_pkt_form
  import dma_stride_pkg::*;
(
  input  logic             valid_i,
  input  xfer_size_e       size_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  output logic [PKT_W-1:0] pkt_o
);

  pkt_t p;

  always_comb begin
    p          = '0;
    p.access   = valid_i;
    p.write    = 1'b0;
    p.size     = size_i;
    p.ctrl     = 4'h0;
    p.tgt_addr = src_i;
    p.payload  = '0;
    p.ret_addr = dst_i;
  end

  assign pkt_o = p;

endmodule

// File: rtl/dma_stride_seq.sv
module dma_stride_seq
  import dma_stride_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int STRIDE_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr_en,
  input  logic [2:0]   reg_wr_sel,
  input  logic [31:0]  reg_wr_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [103:0] out_packet,
  output logic         busy,
  output logic         done
);

  localparam int NCH = 2;

  cfg_t                 cfg;
  logic [NCH-1:0][AW-1:0] inc;
  logic [NCH-1:0][AW-1:0] addr;
  logic [NCH-1:0]       addr_ld;
  logic                 cnt_ld;
  logic                 cnt_nz;
  logic                 hs;

  dma_cfg_regs #(.STRIDE_W(STRIDE_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (reg_wr_en),
    .wr_sel_i  (reg_wr_sel),
    .wr_data_i (reg_wr_data),
    .cfg_o     (cfg),
    .inc_o     (inc)
  );

  assign addr_ld[0] = reg_wr_en && (reg_wr_sel == SEL_SRC);
  assign addr_ld[1] = reg_wr_en && (reg_wr_sel == SEL_DST);
  assign cnt_ld     = reg_wr_en && (reg_wr_sel == SEL_COUNT);
  assign hs         = out_valid && out_ready;

  for (genvar g = 0; g < NCH; g++) begin : g_addr
    dma_addr_step #(.W(AW)) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (addr_ld[g]),
      .load_val_i (reg_wr_data),
      .step_i     (hs),
      .inc_i      (inc[g]),
      .q_o        (addr[g])
    );
  end

  dma_xfer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_ld),
    .load_val_i (reg_wr_data[CNT_W-1:0]),
    .step_i     (hs),
    .nonzero_o  (cnt_nz),
    .done_o     (done)
  );

  assign out_valid = cfg.enable && cfg.master && cnt_nz;
  assign busy      = cfg.enable && cnt_nz;

  dma_pkt_form u_pkt (
    .valid_i (out_valid),
    .size_i  (cfg.size),
    .src_i   (addr[0]),
    .dst_i   (addr[1]),
    .pkt_o   (out_packet)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !reg_wr_en) |=> (out_valid && $stable(out_packet)));

  // R4
  pkt_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_packet[0] && !out_packet[1] && (out_packet[7:4] == 4'h0)));

  // R11
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (reg_wr_sel == SEL_CFG) && !reg_wr_data[0]) |=> !out_valid);

endmodule

// File: tb/dma_stride_seq_tb.sv
module dma_stride_seq_tb_top;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic         rdy   = 1'b0;
  logic         wen   = 1'b0;
  logic [2:0]   wsel  = 3'd0;
  logic [31:0]  wdata = 32'd0;
  logic         out_valid;
  logic [103:0] out_packet;
  logic         busy;
  logic         done;

  int checks   = 0;
  int failures = 0;
  bit cmp_on   = 1'b0;
  bit finished = 1'b0;

  dma_stride_seq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (wen),
    .reg_wr_sel  (wsel),
    .reg_wr_data (wdata),
    .out_valid   (out_valid),
    .out_ready   (rdy),
    .out_packet  (out_packet),
    .busy        (busy),
    .done        (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cfg, m_cnt, m_stride, m_src, m_dst;
  logic        m_done;

  function automatic bit mv();
    return m_cfg[0] && m_cfg[1] && (m_cnt != 0);
  endfunction

  function automatic logic [31:0] stride_amt(input logic [15:0] s, input bit sh);
    longint v;
    v = longint'($signed(s));
    if (sh) v = v * 65536;
    return v[31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg <= 0; m_cnt <= 0; m_stride <= 0; m_src <= 0; m_dst <= 0; m_done <= 0;
    end else begin
      if (mv() && rdy) begin
        m_src <= m_src + stride_amt(m_stride[15:0],  m_cfg[11]);
        m_dst <= m_dst + stride_amt(m_stride[31:16], m_cfg[12]);
        m_cnt <= m_cnt - 1;
      end
      m_done <= mv() && rdy && (m_cnt == 1) && !(wen && wsel == 3'd1);
      if (wen) begin
        case (wsel)
          3'd0: m_cfg    <= wdata;
          3'd1: m_cnt    <= wdata;
          3'd2: m_stride <= wdata;
          3'd3: m_src    <= wdata;
          3'd4: m_dst    <= wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [103:0] act, input logic [103:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [103:0] ep;
      ep = {m_dst, 32'h0, m_src, 4'h0, m_cfg[6:5], 1'b0, mv()};
      check(out_valid === mv(), "R3 valid", {103'd0, out_valid}, {103'd0, mv()});
      check(out_packet === ep, "R4 packet", out_packet, ep);
      check(busy === (m_cfg[0] && m_cnt != 0), "R8 busy", {103'd0, busy},
            {103'd0, (m_cfg[0] && m_cnt != 0)});
      check(done === m_done, "R8 done", {103'd0, done}, {103'd0, m_done});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wen = 1'b1; wsel = s; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic drain(output int n);
    n = 0;
    rdy = 1'b1;
    for (int i = 0; i < 200 && out_valid; i++) begin
      n++;
      @(negedge clk);
    end
    rdy = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [103:0] held;
    int n;

    // R1 reset state
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(out_valid === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 outputs",
          {101'd0, out_valid, busy, done}, 104'd0);
    check(out_packet === 104'd0, "R1 packet", out_packet, 104'd0);
    cmp_on = 1'b1;

    // basic run, word size, negative destination stride
    wr(3'd3, 32'h0000_1000);
    wr(3'd4, 32'h8000_0000);
    wr(3'd2, 32'hFFF8_0004);
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h0000_0043);
    check(out_packet[3:2] === 2'b10 && out_packet[0] === 1'b1, "R4 size/access",
          {100'd0, out_packet[3:0]}, 104'h9);
    check(out_packet[39:8] === 32'h1000, "R4 src field", {72'd0, out_packet[39:8]}, 104'h1000);
    rdy = 1'b1;
    repeat (3) tick();
    check(out_packet[39:8] === 32'h0000_100C, "R5 src step", {72'd0, out_packet[39:8]}, 104'h100C);
    check(out_packet[103:72] === 32'h7FFF_FFE8, "R5 dst step", {72'd0, out_packet[103:72]}, 104'h7FFFFFE8);
    check(done === 1'b1 && out_valid === 1'b0, "R8 done at zero", {102'd0, done, out_valid}, 104'h2);
    rdy = 1'b0;
    tick();
    check(done === 1'b0, "R8 done one cycle", {103'd0, done}, 104'd0);

    // R9 restart by count write, R7 back-pressure
    wr(3'd1, 32'd5);
    check(out_valid === 1'b1 && out_packet[39:8] === 32'h100C, "R9 restart",
          {71'd0, out_valid, out_packet[39:8]}, {71'd0, 1'b1, 32'h100C});
    held = out_packet;
    tick(); tick();
    check(out_valid === 1'b1 && out_packet === held, "R7 hold", out_packet, held);
    for (int i = 0; i < 24; i++) begin
      rdy = (i % 3) != 1;
      tick();
    end
    drain(n);

    // R6 stride shifts
    wr(3'd0, 32'h0000_1843);
    wr(3'd2, 32'h0002_FFFF);
    wr(3'd3, 32'h0005_0000);
    wr(3'd4, 32'h0000_0000);
    wr(3'd1, 32'd1);
    rdy = 1'b1;
    tick();
    check(out_packet[39:8] === 32'h0004_0000, "R6 src shift", {72'd0, out_packet[39:8]}, 104'h40000);
    check(out_packet[103:72] === 32'h0002_0000, "R6 dst shift", {72'd0, out_packet[103:72]}, 104'h20000);
    rdy = 1'b0;

    // R9 / R10 collisions with a handshake
    wr(3'd0, 32'h0000_0003);
    wr(3'd3, 32'h0000_0200);
    wr(3'd4, 32'h0000_0300);
    wr(3'd2, 32'h0010_0001);
    wr(3'd1, 32'd4);
    rdy = 1'b1;
    tick();
    wr(3'd1, 32'd2);
    check(out_packet[39:8] === 32'h202 && out_packet[103:72] === 32'h320 && out_valid === 1'b1,
          "R9 count write with step", {40'd0, out_packet[103:72], out_packet[39:8]},
          {40'd0, 32'h320, 32'h202});
    wr(3'd3, 32'h0000_5000);
    check(out_packet[39:8] === 32'h5000 && out_packet[103:72] === 32'h330, "R10 address write wins",
          {40'd0, out_packet[103:72], out_packet[39:8]}, {40'd0, 32'h330, 32'h5000});
    tick();
    check(done === 1'b1 && out_packet[39:8] === 32'h5001, "R9 written count honored",
          {71'd0, done, out_packet[39:8]}, {71'd0, 1'b1, 32'h5001});
    rdy = 1'b0;

    // R11 disable mid-stream
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h0);
    wr(3'd2, 32'h0001_0001);
    wr(3'd1, 32'd10);
    rdy = 1'b1;
    tick(); tick();
    wr(3'd0, 32'h0000_0002);
    check(out_valid === 1'b0 && busy === 1'b0 && out_packet[39:8] === 32'd3, "R11 last handshake kept",
          {70'd0, out_valid, busy, out_packet[39:8]}, {70'd0, 2'b00, 32'd3});
    repeat (3) tick();
    check(out_packet[39:8] === 32'd3, "R11 held while disabled", {72'd0, out_packet[39:8]}, 104'd3);
    wr(3'd0, 32'h0000_0003);
    drain(n);
    check(n == 7, "R11 remaining count", 104'(n), 104'd7);

    // R12 slave mode
    rdy = 1'b1;
    wr(3'd0, 32'h0000_0001);
    wr(3'd3, 32'h0000_A000);
    wr(3'd4, 32'h0000_B000);
    wr(3'd1, 32'd2);
    repeat (4) tick();
    check(out_valid === 1'b0 && busy === 1'b1, "R12 slave idle",
          {102'd0, out_valid, busy}, 104'h1);
    rdy = 1'b0;
    wr(3'd0, 32'h0000_0003);
    check(out_valid === 1'b1 && out_packet[39:8] === 32'hA000 && out_packet[103:72] === 32'hB000,
          "R12 registers kept", {39'd0, out_valid, out_packet[103:72], out_packet[39:8]},
          {39'd0, 1'b1, 32'hB000, 32'hA000});
    drain(n);

    // R13 wrap-around
    wr(3'd3, 32'h0);
    wr(3'd4, 32'hFFFF_FFFC);
    wr(3'd2, 32'h0004_FFFC);
    wr(3'd1, 32'd1);
    rdy = 1'b1;
    tick();
    check(out_packet[39:8] === 32'hFFFF_FFFC && out_packet[103:72] === 32'h0, "R13 wrap",
          {40'd0, out_packet[103:72], out_packet[39:8]}, {40'd0, 32'h0, 32'hFFFFFFFC});
    rdy = 1'b0;

    // R2 unused selects ignored
    wr(3'd3, 32'h44);
    wr(3'd4, 32'h88);
    for (int s = 5; s < 8; s++) wr(3'(s), 32'hDEAD_BEEF);
    tick();
    check(out_packet[39:8] === 32'h44 && out_packet[103:72] === 32'h88 && out_valid === 1'b0,
          "R2 ignored selects", {39'd0, out_valid, out_packet[103:72], out_packet[39:8]},
          {39'd0, 1'b0, 32'h88, 32'h44});

    repeat (2) tick();
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule